// File: doc/BRIEF.md
# Host Byte Window for Programmed Transfers

This block lets a processor stand in for a DMA engine. Control logic arms it with a buffer start index, a byte length and a tag naming which buffer is being used. The processor then reads from or writes to a single data window. Each access moves one or two bytes between the host data bus and an internal byte buffer. While a transfer is armed, a data-request line stays high. The line drops, and a single completion pulse fires, on the access that uses up the remaining length.

Host writes also consume the external 24-bit transfer counter. The current counter value comes in on a port. Each accepted write returns the decremented value split into three bytes, together with a write-enable pulse, so the register file can store it. Writes are refused while that counter is zero. A side port lets the data-path logic fill the buffer and inspect it.

Top module: `pdma_window`

## Requirements
- R1: After reset, drq, done, tc_we, host_rdata, len_left and moved are all zero.
- R2: An arm pulse sets drq high. In the next cycle, len_left equals arm_len, moved is 0 and origin equals arm_origin.
- R3: A 1-byte write (host_size2=0) stores host_wdata[7:0] at the current index and lowers len_left by 1. The next cycle pulses tc_we, with {tc_hi,tc_mid,tc_lo} equal to tc_in minus 1.
- R4: A 2-byte write (host_size2=1) stores host_wdata[15:8] at the current index and host_wdata[7:0] at the index after it. It lowers len_left by 2 and returns tc_in minus 2.
- R5: A 2-byte read returns the byte at the current index in host_rdata[15:8] and the byte after it in host_rdata[7:0]. The value appears one cycle after the strobe, and len_left drops by 2.
- R6: A 1-byte read returns the byte at the current index in host_rdata[7:0], with bits 15:8 zero, and lowers len_left by 1.
- R7: A write is ignored when tc_in is zero or len_left is zero. In that case tc_we stays low, len_left and moved do not change, and the buffer byte is left as it was.
- R8: A read when len_left is zero returns 0 and leaves len_left and moved unchanged.
- R9: The access that brings len_left to zero lowers drq and raises done for exactly one cycle. Later accesses give no further done pulse until the port is armed again.
- R10: moved equals the current index minus the start index, which is the number of bytes transferred since the last arm.
- R11: A 2-byte access made when only one byte remains sets len_left to 0 instead of wrapping, and raises completion.
- R12: An arm in the same cycle as a host access takes priority. The access is dropped, so no buffer write and no tc_we occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Arm pulse |
| arm_origin | input | 2 | Buffer tag recorded on arm |
| arm_offset | input | IDX_W | Start index in the buffer |
| arm_len | input | LEN_W | Byte count to transfer |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_size2 | input | 1 | 1 for a 2-byte access, 0 for a 1-byte access |
| host_wdata | input | 16 | Host write data |
| tc_in | input | 24 | Current transfer counter |
| side_we | input | 1 | Side port buffer write |
| side_addr | input | IDX_W | Side port index |
| side_wdata | input | 8 | Side port write byte |
| host_rdata | output | 16 | Read data, registered |
| drq | output | 1 | Data request |
| done | output | 1 | Completion pulse |
| len_left | output | LEN_W | Remaining length |
| moved | output | LEN_W | Bytes moved since arm |
| origin | output | 2 | Recorded buffer tag |
| tc_we | output | 1 | Counter write-back strobe |
| tc_lo | output | 8 | Counter bits 7:0 |
| tc_mid | output | 8 | Counter bits 15:8 |
| tc_hi | output | 8 | Counter bits 23:16 |
| side_rdata | output | 8 | Buffer byte at side_addr |

## Verification
Two actions can fall in the same cycle. The first case is the final access, which must write back the counter and fire completion on the same edge. The bench provokes it with a 2-byte write that exhausts the length and checks tc_we, the counter bytes, done and the fall of drq all in one sampled cycle. The second case is an arm asserted together with a write strobe. Here the bench expects the new length, no counter write-back and an untouched buffer byte.

// File: rtl/pdma_window.sv
module pdma_window #(
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic [1:0]                 arm_origin,
  input  logic [$clog2(DEPTH)-1:0]   arm_offset,
  input  logic [$clog2(DEPTH):0]     arm_len,
  input  logic                       host_wr,
  input  logic                       host_rd,
  input  logic                       host_size2,
  input  logic [15:0]                host_wdata,
  input  logic [23:0]                tc_in,
  input  logic                       side_we,
  input  logic [$clog2(DEPTH)-1:0]   side_addr,
  input  logic [7:0]                 side_wdata,
  output logic [15:0]                host_rdata,
  output logic                       drq,
  output logic                       done,
  output logic [$clog2(DEPTH):0]     len_left,
  output logic [$clog2(DEPTH):0]     moved,
  output logic [1:0]                 origin,
  output logic                       tc_we,
  output logic [7:0]                 tc_lo,
  output logic [7:0]                 tc_mid,
  output logic [7:0]                 tc_hi,
  output logic [7:0]                 side_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = IDX_W + 1;

  logic [7:0]       mem [DEPTH];
  logic [LEN_W-1:0] start_q, cur_q, len_q;
  logic [23:0]      tc_q;
  logic             armed_q;

  wire              len_nz = (len_q != '0);
  wire              wr_go  = host_wr && !arm && len_nz && (tc_in != 24'd0);
  wire              rd_go  = host_rd && !host_wr && !arm && len_nz;
  wire              rd_nil = host_rd && !host_wr && !arm && !len_nz;
  wire [LEN_W-1:0]  step   = host_size2 ? LEN_W'(2) : LEN_W'(1);
  wire [LEN_W-1:0]  len_nx = (len_q > step) ? len_q - step : '0;
  wire [IDX_W-1:0]  idx0   = cur_q[IDX_W-1:0];
  wire [IDX_W-1:0]  idx1   = idx0 + IDX_W'(1);

  assign len_left   = len_q;
  assign moved      = cur_q - start_q;
  assign {tc_hi, tc_mid, tc_lo} = tc_q;
  assign side_rdata = mem[side_addr];

  always_ff @(posedge clk) begin
    if (side_we) mem[side_addr] <= side_wdata;
    if (wr_go) begin
      if (host_size2) begin
        mem[idx0] <= host_wdata[15:8];
        mem[idx1] <= host_wdata[7:0];
      end else begin
        mem[idx0] <= host_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= '0;
      cur_q      <= '0;
      len_q      <= '0;
      origin     <= '0;
      armed_q    <= 1'b0;
      drq        <= 1'b0;
      done       <= 1'b0;
      tc_we      <= 1'b0;
      tc_q       <= '0;
      host_rdata <= '0;
    end else begin
      done  <= 1'b0;
      tc_we <= 1'b0;
      if (arm) begin
        origin  <= arm_origin;
        start_q <= LEN_W'(arm_offset);
        cur_q   <= LEN_W'(arm_offset);
        len_q   <= arm_len;
        armed_q <= 1'b1;
        drq     <= 1'b1;
      end else if (wr_go || rd_go) begin
        cur_q <= cur_q + step;
        len_q <= len_nx;
        if (len_nx == '0 && armed_q) begin
          drq     <= 1'b0;
          done    <= 1'b1;
          armed_q <= 1'b0;
        end
        if (wr_go) begin
          tc_we <= 1'b1;
          tc_q  <= tc_in - 24'(step);
        end else begin
          host_rdata <= host_size2 ? {mem[idx0], mem[idx1]} : {8'h00, mem[idx0]};
        end
      end else if (rd_nil) begin
        host_rdata <= '0;
      end
    end
  end

  a_r9_done_drops_drq: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drq);
  a_r9_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_no_wb_tc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !arm && tc_in == 24'd0) |=> !tc_we);
  a_r8_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && !arm && len_left == '0) |=> (host_rdata == '0 && $stable(len_left)));
  a_r11_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && host_size2 && !arm && len_left == LEN_W'(1) && tc_in != 24'd0)
      |=> (len_left == '0 && done));
  a_r12_arm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (len_left == $past(arm_len) && !tc_we && drq));
endmodule

// File: tb/test_pdma_window.sv
`timescale 1ns/1ps
module test_pdma_window;
  logic clk = 0, rst_n = 0;
  logic arm = 0, host_wr = 0, host_rd = 0, host_size2 = 0, side_we = 0;
  logic [1:0] arm_origin = 0;
  logic [4:0] arm_offset = 0, side_addr = 0;
  logic [5:0] arm_len = 0;
  logic [15:0] host_wdata = 0;
  logic [23:0] tc_in = 0;
  logic [7:0] side_wdata = 0;
  logic [15:0] host_rdata;
  logic drq, done, tc_we;
  logic [5:0] len_left, moved;
  logic [1:0] origin;
  logic [7:0] tc_lo, tc_mid, tc_hi, side_rdata;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pdma_window i_pdma_window (.*);

  typedef struct packed {
    logic [1:0] op; logic sz; logic [15:0] d; logic [23:0] tc;
    logic [5:0] elen; logic ewe; logic [23:0] etc; logic [15:0] erd;
    logic edone; logic edrq;
  } vec_t;

  localparam int N = 12;
  localparam vec_t V [N] = '{
    '{2'd2, 1'b0, 16'h0004, 24'd6,   6'd6, 1'b0, 24'd0,  16'h0000, 1'b0, 1'b1},
    '{2'd0, 1'b0, 16'h00A5, 24'd100, 6'd5, 1'b1, 24'd99, 16'h0000, 1'b0, 1'b1},
    '{2'd0, 1'b1, 16'h1234, 24'd99,  6'd3, 1'b1, 24'd97, 16'h0000, 1'b0, 1'b1},
    '{2'd0, 1'b0, 16'h005A, 24'd0,   6'd3, 1'b0, 24'd0,  16'h0000, 1'b0, 1'b1},
    '{2'd0, 1'b1, 16'hBEEF, 24'd97,  6'd1, 1'b1, 24'd95, 16'h0000, 1'b0, 1'b1},
    '{2'd0, 1'b1, 16'hC0DE, 24'd95,  6'd0, 1'b1, 24'd93, 16'h0000, 1'b1, 1'b0},
    '{2'd2, 1'b0, 16'h0004, 24'd7,   6'd7, 1'b0, 24'd0,  16'h0000, 1'b0, 1'b1},
    '{2'd1, 1'b1, 16'h0000, 24'd0,   6'd5, 1'b0, 24'd0,  16'hA512, 1'b0, 1'b1},
    '{2'd1, 1'b0, 16'h0000, 24'd0,   6'd4, 1'b0, 24'd0,  16'h0034, 1'b0, 1'b1},
    '{2'd1, 1'b1, 16'h0000, 24'd0,   6'd2, 1'b0, 24'd0,  16'hBEEF, 1'b0, 1'b1},
    '{2'd1, 1'b1, 16'h0000, 24'd0,   6'd0, 1'b0, 24'd0,  16'hC0DE, 1'b1, 1'b0},
    '{2'd1, 1'b1, 16'h0000, 24'd0,   6'd0, 1'b0, 24'd0,  16'h0000, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear();
    arm = 0; host_wr = 0; host_rd = 0; side_we = 0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(drq == 0 && done == 0 && tc_we == 0 && host_rdata == 0 && len_left == 0 && moved == 0,
        "R1 reset", {drq, done, tc_we, len_left}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      host_size2 = V[i].sz; host_wdata = V[i].d; tc_in = V[i].tc;
      case (V[i].op)
        2'd0: host_wr = 1;
        2'd1: host_rd = 1;
        default: begin arm = 1; arm_origin = 2'd1; arm_offset = V[i].d[4:0]; arm_len = V[i].tc[5:0]; end
      endcase
      step();
      clear();
      chk(len_left == V[i].elen, "R3/R4/R5/R6/R7/R11 len_left", len_left, V[i].elen);
      chk(tc_we == V[i].ewe, "R3/R4/R7 tc_we", tc_we, V[i].ewe);
      if (V[i].ewe) chk({tc_hi, tc_mid, tc_lo} == V[i].etc, "R3/R4 counter bytes",
                        {tc_hi, tc_mid, tc_lo}, V[i].etc);
      if (V[i].op == 2'd1) chk(host_rdata == V[i].erd, "R5/R6/R8 read data", host_rdata, V[i].erd);
      chk(done == V[i].edone, "R9 done", done, V[i].edone);
      chk(drq == V[i].edrq, "R2/R9 drq", drq, V[i].edrq);
      if (i == 0) chk(origin == 2'd1 && moved == 0, "R2 origin/moved", {origin, moved}, 8'h40);
      if (i == 3) chk(moved == 3, "R7 moved unchanged", moved, 3);
      if (i == 5) chk(moved == 7, "R10 moved", moved, 7);
    end
    chk(moved == 7, "R10 moved after reads", moved, 7);
    side_addr = 5'd7;
    #1 chk(side_rdata == 8'hBE, "R4 high byte first", side_rdata, 8'hBE);
    side_addr = 5'd8;
    #1 chk(side_rdata == 8'hEF, "R4 low byte second", side_rdata, 8'hEF);

    side_we = 1; side_addr = 5'd20; side_wdata = 8'h77;
    arm = 1; arm_offset = 5'd20; arm_len = 6'd2; arm_origin = 2'd2;
    step(); clear();
    host_wr = 1; host_size2 = 0; host_wdata = 16'h0099; tc_in = 0;
    step(); clear();
    chk(!tc_we && len_left == 2 && moved == 0, "R7 tc zero write ignored", {tc_we, len_left}, 2);
    #1 chk(side_rdata == 8'h77, "R7 buffer untouched", side_rdata, 8'h77);

    arm = 1; arm_len = 6'd5; arm_offset = 5'd20;
    host_wr = 1; host_wdata = 16'h0055; tc_in = 24'd9;
    step(); clear();
    chk(len_left == 5 && !tc_we && drq, "R12 arm wins", {len_left, tc_we}, 10);
    #1 chk(side_rdata == 8'h77, "R12 no buffer write", side_rdata, 8'h77);

    arm = 1; arm_len = 6'd0;
    step(); clear();
    host_wr = 1; tc_in = 24'd5;
    step(); clear();
    chk(!tc_we && len_left == 0 && !done, "R7 zero length write ignored", {tc_we, done}, 0);
    host_rd = 1; host_size2 = 1;
    step(); clear();
    chk(host_rdata == 0 && moved == 0, "R8 zero length read", host_rdata, 0);

    arm = 1; arm_len = 6'd1; arm_offset = 5'd0;
    step(); clear();
    host_wr = 1; host_size2 = 1; host_wdata = 16'h1122; tc_in = 24'h010000;
    step(); clear();
    chk(len_left == 0 && done && !drq, "R11 clamp and complete", {len_left, done}, 1);
    chk({tc_hi, tc_mid, tc_lo} == 24'h00FFFE, "R3 counter borrow", {tc_hi, tc_mid, tc_lo}, 24'h00FFFE);
    step();
    chk(!done, "R9 single pulse", done, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule